// File: doc/BRIEF.md
# On-off keyed carrier modulator

This block turns a baseband bit stream into an on-off keyed square-wave carrier for a coaxial modem's analog output stage. It runs from a reference clock at four times the carrier frequency, so an 8.704 MHz reference gives a 2.176 MHz carrier. The keying is active-low. While the transmit data line is low the carrier toggles on `carrier_out`. While the line is high the output is silent.

A two-bit rate select comes with the data. Three of its codes are active modes, and in all three the modulator follows the data line. The code `2'b11` is standby: it gates the transmitter off whatever the data line does. The block has no receive-path input, so the data line keys the carrier in every active mode with no reference to receive activity. Both the data line and the select are brought into the reference domain through flip-flop synchronisers. A keying decision that would end a burst takes effect only at the end of a carrier period, so every burst is a whole number of carrier cycles. `carrier_active` marks every reference cycle in which the carrier is emitted. `tx_quiet` is its complement and tells the analog stage to idle.

Top module: `ook_modulator`

## Requirements
- R1: While `rst_n` is low, and for the first reference cycles after it is released, `carrier_out` and `carrier_active` are 0 and `tx_quiet` is 1, even if `tx_din` is low.
- R2: While the carrier is emitted, `carrier_out` is high for 2 reference cycles and then low for 2, a period of exactly 4 reference cycles. Each burst begins with the high half.
- R3: With `rate_sel` at `2'b00`, `2'b01` or `2'b10`, a low `tx_din` emits the carrier and a high `tx_din` silences it. Switching between these three codes in the middle of a burst does not interrupt it.
- R4: With `rate_sel` at `2'b11` (standby) no carrier is emitted, whatever `tx_din` does. Entering standby in the middle of a burst ends the burst at the next period boundary.
- R5: From idle, after `tx_din` falls in an active mode, `carrier_active` is 1 after the third rising reference edge (two synchroniser stages plus one keying register).
- R6: A burst ends only after a whole carrier period. For a low pulse of N reference cycles on `tx_din` that starts from idle, `carrier_active` stays high for 4*ceil(N/4) cycles.
- R7: Whenever `carrier_active` is 0, `carrier_out` is held at 0. `tx_quiet` is always the complement of `carrier_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, four times the carrier frequency |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_din | input | 1 | Baseband transmit data; low keys the carrier on |
| rate_sel | input | 2 | Rate select; `2'b11` is standby, the other codes are active |
| carrier_out | output | 1 | Digital square-wave carrier, 0 when gated off |
| carrier_active | output | 1 | 1 during each reference cycle in which the carrier is emitted |
| tx_quiet | output | 1 | 1 when the analog output stage must stay silent |

## Verification
The bench sweeps low-pulse lengths from 1 to 9 reference cycles through all four select codes. It covers the lengths just under and just over a carrier period. A design that released the carrier as soon as the data returned high would give runt bursts of 1 to 3 cycles there, and burst lengths other than the rounded-up multiple of four. Further sequences enter standby in the middle of a burst, hop between the active codes while the line stays low, and insert a one-cycle high glitch inside a burst. A design that keyed off immediately, dropped the carrier on a code change, or let standby pass the data through would show a different cycle-by-cycle trace from the bench's arithmetic expectation. A long burst measures the spacing of the carrier's rising edges, which catches a wrong divide ratio or a wrong duty split.

// File: rtl/ook_pkg.sv
package ook_pkg;

  // Rate / standby select encoding. Only the standby code changes the
  // modulator's behaviour; the three rate codes are accepted as active.
  typedef enum logic [1:0] {
    RATE_SLOW    = 2'b00,
    RATE_MID     = 2'b01,
    RATE_FAST    = 2'b10,
    RATE_STANDBY = 2'b11
  } ook_rate_e;

  function automatic logic rate_is_standby(input logic [1:0] sel);
    return sel == RATE_STANDBY;
  endfunction

  // Idle level of the transmit data line (active-low keying).
  localparam logic TX_IDLE_LEVEL = 1'b1;

endpackage

// File: rtl/ook_reset_sync.sv
module ook_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ook_bit_sync.sv
module ook_bit_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= RST_VAL;
      end
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= stage_d[i];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ook_key_ctrl.sv
module ook_key_ctrl #(
  parameter int DIV_RATIO = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         want_on,
  output logic                         key_on,
  output logic [$clog2(DIV_RATIO)-1:0] phase,
  output logic                         carrier_lvl
);

  localparam int                 PW      = $clog2(DIV_RATIO);
  localparam logic [PW-1:0]      LAST_PH = PW'(DIV_RATIO - 1);
  localparam logic [PW-1:0]      HALF_PH = PW'(DIV_RATIO / 2);

  logic          key_q, key_d;
  logic [PW-1:0] phase_q, phase_d;
  logic          at_boundary;

  // A key decision is accepted while idle or on the last phase of a period.
  always_comb begin
    at_boundary = !key_q || (phase_q == LAST_PH);
    key_d       = want_on;
    if (!key_q) begin
      phase_d = '0;
    end else if (phase_q == LAST_PH) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= 1'b0;
    end else if (at_boundary) begin
      key_q <= key_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign key_on      = key_q;
  assign phase       = phase_q;
  assign carrier_lvl = key_q && (phase_q < HALF_PH);

endmodule

// File: rtl/ook_modulator.sv
module ook_modulator #(
  parameter int DIV_RATIO   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       tx_din,
  input  logic [1:0] rate_sel,
  output logic       carrier_out,
  output logic       carrier_active,
  output logic       tx_quiet
);

  import ook_pkg::*;

  localparam int PW = $clog2(DIV_RATIO);

  logic          rst_core_n;
  logic [2:0]    sync_q;
  logic          tx_s;
  logic [1:0]    rate_s;
  logic          want_on;
  logic          key_on;
  logic [PW-1:0] phase;
  logic          carrier_lvl;

  ook_reset_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk_ref),
    .arst_n     (rst_n),
    .rst_n_sync (rst_core_n)
  );

  // Select and data share one synchroniser; reset value is standby + idle.
  ook_bit_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({RATE_STANDBY, TX_IDLE_LEVEL})
  ) u_in_sync (
    .clk   (clk_ref),
    .rst_n (rst_core_n),
    .d     ({rate_sel, tx_din}),
    .q     (sync_q)
  );

  assign tx_s   = sync_q[0];
  assign rate_s = sync_q[2:1];

  always_comb begin
    want_on = (tx_s != TX_IDLE_LEVEL) && !rate_is_standby(rate_s);
  end

  ook_key_ctrl #(.DIV_RATIO(DIV_RATIO)) u_key (
    .clk         (clk_ref),
    .rst_n       (rst_core_n),
    .want_on     (want_on),
    .key_on      (key_on),
    .phase       (phase),
    .carrier_lvl (carrier_lvl)
  );

  assign carrier_out    = carrier_lvl;
  assign carrier_active = key_on;
  assign tx_quiet       = !key_on;

endmodule

// File: rtl/ook_modulator_chk.sv
module ook_modulator_chk #(
  parameter int DIV_RATIO   = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic       clk_ref,
  input logic       rst_n,
  input logic       tx_din,
  input logic [1:0] rate_sel,
  input logic       carrier_out,
  input logic       carrier_active,
  input logic       tx_quiet
);

  localparam int LAT  = SYNC_STAGES + 1;
  localparam int LIM  = SYNC_STAGES + DIV_RATIO;
  localparam int CW   = $clog2(LIM + 1) + 1;
  localparam int RW   = $clog2(DIV_RATIO) + 1;
  localparam int HALF = DIV_RATIO / 2;

  logic [RW-1:0] run_cnt;
  logic [CW-1:0] stby_cnt;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      stby_cnt <= '0;
      idle_cnt <= '0;
    end else begin
      if (!carrier_active)                      run_cnt <= '0;
      else if (run_cnt == RW'(DIV_RATIO - 1))   run_cnt <= '0;
      else                                      run_cnt <= run_cnt + 1'b1;
      if (rate_sel != 2'b11)                    stby_cnt <= '0;
      else if (stby_cnt < CW'(LIM))             stby_cnt <= stby_cnt + 1'b1;
      if (tx_din != 1'b1)                       idle_cnt <= '0;
      else if (idle_cnt < CW'(LIM))             idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_ref)
    !rst_n |-> (tx_quiet && !carrier_active && !carrier_out));

  assert_carrier_shape_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    carrier_active |-> (carrier_out == (run_cnt < RW'(HALF))));

  assert_idle_silences_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (idle_cnt >= CW'(LIM)) |-> !carrier_active);

  assert_standby_silences_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (stby_cnt >= CW'(LIM)) |-> !carrier_active);

  assert_start_latency_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(carrier_active) |-> (($past(tx_din, LAT) == 1'b0) && ($past(rate_sel, LAT) != 2'b11)));

  assert_whole_periods_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(carrier_active) |-> (run_cnt == '0));

  assert_gated_low_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !carrier_active |-> !carrier_out);

endmodule

bind ook_modulator ook_modulator_chk #(
  .DIV_RATIO   (DIV_RATIO),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk_ref        (clk_ref),
  .rst_n          (rst_n),
  .tx_din         (tx_din),
  .rate_sel       (rate_sel),
  .carrier_out    (carrier_out),
  .carrier_active (carrier_active),
  .tx_quiet       (tx_quiet)
);

// File: tb/tb_ook_modulator.sv
module tb_ook_modulator;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int WATCHDOG   = 50000;

  logic       clk_ref;
  logic       rst_n;
  logic       tx_din;
  logic [1:0] rate_sel;
  logic       carrier_out;
  logic       carrier_active;
  logic       tx_quiet;

  int errors;
  int checks;
  int cycles;
  bit done;

  // Expected-behaviour state, derived from the requirements:
  // two synchroniser stages, one keying register, period boundary rule.
  logic [2:0] m_s1, m_s2;
  logic       m_key;
  int         m_ph;
  bit         model_on;

  ook_modulator #(.DIV_RATIO(DIV), .SYNC_STAGES(2)) dut (
    .clk_ref        (clk_ref),
    .rst_n          (rst_n),
    .tx_din         (tx_din),
    .rate_sel       (rate_sel),
    .carrier_out    (carrier_out),
    .carrier_active (carrier_active),
    .tx_quiet       (tx_quiet)
  );

  initial clk_ref = 1'b0;
  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk_ref) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG && !done) begin
      done = 1'b1;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // One reference cycle: advance the expected state at the edge, compare after it.
  task automatic tick();
    logic want, n_key;
    int   n_ph;
    @(posedge clk_ref);
    if (model_on) begin
      want  = (m_s2[0] == 1'b0) && (m_s2[2:1] != 2'b11);
      n_key = (!m_key || m_ph == DIV-1) ? want : m_key;
      n_ph  = m_key ? (m_ph + 1) % DIV : 0;
      m_s2  = m_s1;
      m_s1  = {rate_sel, tx_din};
      m_key = n_key;
      m_ph  = n_ph;
    end
    @(negedge clk_ref);
    if (model_on) begin
      // R2 carrier waveform, R3 keying, R7 quiet flag
      check(carrier_out == (m_key && m_ph < DIV/2), "R2 carrier_out",
            int'(carrier_out), int'(m_key && m_ph < DIV/2));
      check(carrier_active == m_key, (m_s2[2:1] == 2'b11) ? "R4 carrier_active" : "R3 carrier_active",
            int'(carrier_active), int'(m_key));
      check(tx_quiet == !carrier_active, "R7 tx_quiet", int'(tx_quiet), int'(!carrier_active));
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    int burst, first, last_rise, spacing_bad, rises;
    errors = 0; checks = 0; cycles = 0; done = 1'b0; model_on = 1'b0;
    rst_n = 1'b1; tx_din = 1'b0; rate_sel = 2'b00;
    #1 rst_n = 1'b0;

    // R1: reset holds the transmitter silent even with data low
    repeat (4) @(negedge clk_ref);
    check(carrier_out == 1'b0, "R1 carrier_out in reset", int'(carrier_out), 0);
    check(carrier_active == 1'b0, "R1 carrier_active in reset", int'(carrier_active), 0);
    check(tx_quiet == 1'b1, "R1 tx_quiet in reset", int'(tx_quiet), 1);
    tx_din = 1'b1;
    rst_n  = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_ref);
      check(tx_quiet == 1'b1 && carrier_out == 1'b0, "R1 quiet after release",
            int'(tx_quiet), 1);
    end
    repeat (6) @(negedge clk_ref);
    m_s1 = {rate_sel, tx_din}; m_s2 = m_s1; m_key = 1'b0; m_ph = 0;
    model_on = 1'b1;

    // Sweep: every select code, low pulses of 1..9 cycles
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= 9; n++) begin
        rate_sel = 2'(m);
        ticks(8);
        tx_din = 1'b0;
        burst = 0; first = -1;
        for (int t = 1; t <= n + 16; t++) begin
          if (t == n + 1) tx_din = 1'b1;
          tick();
          if (carrier_active) begin
            burst++;
            if (first < 0) first = t;
          end
        end
        if (m == 3) begin
          check(burst == 0, "R4 standby burst length", burst, 0);
        end else begin
          check(burst == DIV * ((n + DIV - 1) / DIV), "R6 burst length", burst,
                DIV * ((n + DIV - 1) / DIV));
          check(first == 3, "R5 start latency", first, 3);
        end
      end
    end

    // R4: standby entered mid-burst ends on a period boundary
    rate_sel = 2'b00; ticks(6);
    tx_din = 1'b0; ticks(6);
    rate_sel = 2'b11; ticks(12);
    check(carrier_active == 1'b0, "R4 standby mid-burst", int'(carrier_active), 0);
    tx_din = 1'b1; ticks(4);
    rate_sel = 2'b00; ticks(6);

    // R3: hopping between active codes keeps the burst running
    tx_din = 1'b0; ticks(5);
    rate_sel = 2'b01; ticks(5);
    rate_sel = 2'b10; ticks(5);
    rate_sel = 2'b00; ticks(5);
    check(carrier_active == 1'b1, "R3 burst across code changes", int'(carrier_active), 1);
    tx_din = 1'b1; ticks(10);

    // R6: one-cycle high glitch inside a burst
    tx_din = 1'b0; ticks(3);
    tx_din = 1'b1; tick();
    tx_din = 1'b0; ticks(3);
    tx_din = 1'b1; ticks(12);
    check(carrier_active == 1'b0, "R6 glitch burst ends", int'(carrier_active), 0);

    // R2: long burst, carrier rising edges spaced by the divide ratio
    tx_din = 1'b0;
    last_rise = -1; spacing_bad = 0; rises = 0;
    for (int t = 0; t < 40; t++) begin
      logic prev;
      prev = carrier_out;
      tick();
      if (carrier_out && !prev) begin
        if (last_rise >= 0 && (t - last_rise) != DIV) spacing_bad++;
        last_rise = t; rises++;
      end
    end
    check(spacing_bad == 0, "R2 carrier period", spacing_bad, 0);
    check(rises >= 9, "R2 carrier edge count", rises, 9);
    tx_din = 1'b1; ticks(10);
    check(tx_quiet == 1'b1 && carrier_out == 1'b0, "R7 silent after burst", int'(tx_quiet), 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule